// File: doc/BRIEF.md
# Board Control Register Bank

A memory-mapped bank of board housekeeping registers on a simple 32-bit bus. The bus has an address, a write strobe with write data, and a read strobe whose data comes back registered. The bank holds the value for an eight-lamp LED bar, an eight-character ASCII display buffer, a break/reset byte and a general-purpose output byte. It also holds a group of registers through which software bit-bangs an I2C link to an external serial EEPROM.

The display can be loaded one character at a time. It can also be loaded with one word write, which the bank turns into eight uppercase hexadecimal ASCII digits. Writing a fixed key value to the soft-reset offset produces a one-cycle reset request. The I2C clock and data lines come straight from two bits of the I2C output register. The data level returned by the EEPROM shows up in bit 0 of the I2C input register. A select bit chooses whether the general-purpose input offset loops back the I2C output register or reads zero.

Top module: `board_ctl_bank`

## Requirements
- R1: After reset the stored values are: LEDs 0x00, break/reset 0x0A, general-purpose output 0x00, I2C output-enable 0, I2C output 0x3, I2C select 1. Every display character is 0x20. `i2c_scl_o` and `i2c_sda_o` are 1, `reset_req_o` is 0 and `bus_rdata` is 0.
- R2: Only `bus_addr[19:0]` is decoded, so the upper address bits do not matter. A read of an offset that is not in the map returns 0. A write to such an offset changes no state.
- R3: A read takes `bus_rdata` from the state before the edge that samples `bus_re`, and shows it from that edge on. While `bus_re` is low, `bus_rdata` keeps its value.
- R4: Offsets 0x200 (switches) and 0x210 (jumpers) always read 0, and writes to them are ignored. Offset 0x208 (status) is read-only: it returns 0x12 while `strap_big_endian` is 1 and 0x10 otherwise.
- R5: Offsets 0x408 (LEDs), 0x508 (break/reset) and 0xA00 (general-purpose output) each keep `bus_wdata[7:0]` and read back with bits 31:8 at zero.
- R6: A write to 0x410 sets all display characters to the uppercase hex ASCII digits of `bus_wdata`. Character 0 gets bits 31:28 and character 7 gets bits 3:0. Digits 0-9 become 0x30-0x39 and A-F become 0x41-0x46. Character i is `disp_chars_o[8*i+7:8*i]`.
- R7: A write to 0x418 + 8*i (i = 0..7) sets character i to `bus_wdata[7:0]` and leaves the other characters alone. Offsets in that range that are not multiples of 8 are unmapped.
- R8: A write of exactly 0x00000042 to 0x500 makes `reset_req_o` 1 for exactly the next cycle. Any other value written there has no effect.
- R9: Offset 0xB08 (I2C output-enable) keeps `bus_wdata[1:0]`. Offset 0xB18 (I2C select) keeps `bus_wdata[0]`. Both read back zero-extended.
- R10: A write to 0xB10 keeps all 32 bits of `bus_wdata`, and they read back unchanged. From the next cycle on, `i2c_scl_o` is bit 1 and `i2c_sda_o` is bit 0. The two lines change only on such a write.
- R11: Offset 0xA08 returns the I2C output register while the select bit is 1, and 0 while it is 0.
- R12: Offset 0xB00 returns 0x00000002 with bit 0 replaced by `i2c_sda_i`, sampled on the read edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 32 | Byte address; only bits 19:0 are decoded |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| strap_big_endian | input | 1 | Byte-order strap shown in the status register |
| i2c_sda_i | input | 1 | SDA level returned by the EEPROM |
| i2c_scl_o | output | 1 | I2C clock line driven to the EEPROM |
| i2c_sda_o | output | 1 | I2C data line driven to the EEPROM |
| reset_req_o | output | 1 | One-cycle soft-reset request |
| disp_chars_o | output | 64 | Display characters, character i in bits 8i+7:8i |

## Verification
The assertions watch, on every cycle:
- the read data path: it holds while no read is made, unmapped reads return zero, and the byte registers read back with clear upper bits;
- the reset-request pulse: it lasts one cycle and follows the key write;
- the I2C lines: they copy the written bits and are otherwise steady;
- the display vector: it changes only after a display write.

The hex expansion, the per-character indexing, the reset values, the status strap, the loopback select and the ignoring of aliased or unmapped writes depend on particular data. Only the bench's directed scenarios can show those.

// File: rtl/bcb_pkg.sv
`timescale 1ns/1ps
package bcb_pkg;
  localparam int DATA_W = 32;
  localparam int OFS_W  = 20;

  localparam logic [OFS_W-1:0] OFS_SWITCH  = 20'h00200;
  localparam logic [OFS_W-1:0] OFS_STATUS  = 20'h00208;
  localparam logic [OFS_W-1:0] OFS_JUMPER  = 20'h00210;
  localparam logic [OFS_W-1:0] OFS_LEDS    = 20'h00408;
  localparam logic [OFS_W-1:0] OFS_HEXWORD = 20'h00410;
  localparam logic [OFS_W-1:0] OFS_CHAR0   = 20'h00418;
  localparam logic [OFS_W-1:0] OFS_SOFTRST = 20'h00500;
  localparam logic [OFS_W-1:0] OFS_BRKRST  = 20'h00508;
  localparam logic [OFS_W-1:0] OFS_GPOUT   = 20'h00A00;
  localparam logic [OFS_W-1:0] OFS_GPIN    = 20'h00A08;
  localparam logic [OFS_W-1:0] OFS_I2CIN   = 20'h00B00;
  localparam logic [OFS_W-1:0] OFS_I2COE   = 20'h00B08;
  localparam logic [OFS_W-1:0] OFS_I2COUT  = 20'h00B10;
  localparam logic [OFS_W-1:0] OFS_I2CSEL  = 20'h00B18;

  localparam logic [DATA_W-1:0] SOFTRST_KEY = 32'h0000_0042;
  localparam logic [DATA_W-1:0] I2CIN_RST   = 32'h0000_0003;
  localparam logic [DATA_W-1:0] I2COUT_RST  = 32'h0000_0003;
  localparam logic [7:0]        BRK_RST     = 8'h0A;
  localparam logic [7:0]        BLANK_CHAR  = 8'h20;
  localparam logic [DATA_W-1:0] STATUS_BE   = 32'h12;
  localparam logic [DATA_W-1:0] STATUS_LE   = 32'h10;

  typedef struct packed {
    logic sw;
    logic status;
    logic jumper;
    logic leds;
    logic hexword;
    logic chr;
    logic softrst;
    logic brk;
    logic gpout;
    logic gpin;
    logic i2cin;
    logic i2coe;
    logic i2cout;
    logic i2csel;
  } sel_t;

  // One nibble to its uppercase hex ASCII code.
  function automatic logic [7:0] hex_ascii(input logic [3:0] n);
    logic [7:0] base;
    base = (n > 4'd9) ? 8'd55 : 8'd48;
    return base + {4'b0, n};
  endfunction
endpackage

// File: rtl/bcb_decode.sv
`timescale 1ns/1ps
module bcb_decode
  import bcb_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int NUM_CHARS = 8,
  parameter int CIDX_W    = $clog2(NUM_CHARS)
) (
  input  logic [ADDR_W-1:0] addr,
  output sel_t              sel,
  output logic [CIDX_W-1:0] chr_idx,
  output logic              rd_hit
);
  logic [OFS_W-1:0] ofs;
  logic [OFS_W-1:0] chr_rel;
  logic             unused_hi;

  assign ofs       = addr[OFS_W-1:0];
  assign unused_hi = ^addr[ADDR_W-1:OFS_W];
  assign chr_rel   = ofs - OFS_CHAR0;
  assign chr_idx   = chr_rel[CIDX_W+2:3];

  always_comb begin
    sel         = '0;
    sel.sw      = (ofs == OFS_SWITCH);
    sel.status  = (ofs == OFS_STATUS);
    sel.jumper  = (ofs == OFS_JUMPER);
    sel.leds    = (ofs == OFS_LEDS);
    sel.hexword = (ofs == OFS_HEXWORD);
    sel.chr     = (ofs >= OFS_CHAR0) && (chr_rel[2:0] == 3'b000) &&
                  (chr_rel[OFS_W-1:3] < (OFS_W-3)'(NUM_CHARS));
    sel.softrst = (ofs == OFS_SOFTRST);
    sel.brk     = (ofs == OFS_BRKRST);
    sel.gpout   = (ofs == OFS_GPOUT);
    sel.gpin    = (ofs == OFS_GPIN);
    sel.i2cin   = (ofs == OFS_I2CIN);
    sel.i2coe   = (ofs == OFS_I2COE);
    sel.i2cout  = (ofs == OFS_I2COUT);
    sel.i2csel  = (ofs == OFS_I2CSEL);
  end

  assign rd_hit = sel.sw | sel.status | sel.jumper | sel.leds | sel.brk |
                  sel.gpout | sel.gpin | sel.i2cin | sel.i2coe |
                  sel.i2cout | sel.i2csel;
endmodule

// File: rtl/bcb_display.sv
`timescale 1ns/1ps
module bcb_display
  import bcb_pkg::*;
#(
  parameter int NUM_CHARS = 8,
  parameter int CIDX_W    = $clog2(NUM_CHARS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_word,
  input  logic                   wr_chr,
  input  logic [CIDX_W-1:0]      chr_idx,
  input  logic [DATA_W-1:0]      wdata,
  output logic [NUM_CHARS*8-1:0] chars_o
);
  for (genvar g = 0; g < NUM_CHARS; g++) begin : g_char
    logic [7:0] ch_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ch_q <= BLANK_CHAR;
      end else if (wr_word) begin
        ch_q <= hex_ascii(wdata[DATA_W-1-4*g -: 4]);
      end else if (wr_chr && (chr_idx == CIDX_W'(g))) begin
        ch_q <= wdata[7:0];
      end
    end
    assign chars_o[8*g +: 8] = ch_q;
  end
endmodule

// File: rtl/bcb_i2c.sv
`timescale 1ns/1ps
module bcb_i2c
  import bcb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_oe,
  input  logic              wr_out,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wdata,
  input  logic              sda_in,
  output logic [DATA_W-1:0] out_q,
  output logic [1:0]        oe_q,
  output logic              sel_q,
  output logic [DATA_W-1:0] in_word,
  output logic              scl_o,
  output logic              sda_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= I2COUT_RST;
      oe_q  <= 2'b00;
      sel_q <= 1'b1;
    end else begin
      if (wr_out) out_q <= wdata;
      if (wr_oe)  oe_q  <= wdata[1:0];
      if (wr_sel) sel_q <= wdata[0];
    end
  end

  assign scl_o   = out_q[1];
  assign sda_o   = out_q[0];
  assign in_word = {I2CIN_RST[DATA_W-1:1], sda_in};
endmodule

// File: rtl/board_ctl_bank.sv
`timescale 1ns/1ps
module board_ctl_bank
  import bcb_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int NUM_CHARS = 8,
  localparam int CIDX_W   = $clog2(NUM_CHARS),
  localparam int DISP_W   = NUM_CHARS * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_re,
  output logic [31:0]       bus_rdata,
  input  logic              strap_big_endian,
  input  logic              i2c_sda_i,
  output logic              i2c_scl_o,
  output logic              i2c_sda_o,
  output logic              reset_req_o,
  output logic [DISP_W-1:0] disp_chars_o
);
  sel_t              sel;
  logic [CIDX_W-1:0] chr_idx;
  logic              rd_hit;

  // Named internal events used by the checker.
  logic              disp_wr_evt;
  logic              key_wr_evt;

  logic [7:0]        leds_q, brk_q, gpout_q;
  logic              rst_req_q;
  logic [31:0]       rdata_q, rd_mux;
  logic [31:0]       i2c_out_q, i2c_in_word;
  logic [1:0]        i2c_oe_q;
  logic              i2c_sel_q;

  bcb_decode #(.ADDR_W(ADDR_W), .NUM_CHARS(NUM_CHARS), .CIDX_W(CIDX_W)) u_dec (
    .addr    (bus_addr),
    .sel     (sel),
    .chr_idx (chr_idx),
    .rd_hit  (rd_hit)
  );

  assign disp_wr_evt = bus_we && (sel.hexword || sel.chr);
  assign key_wr_evt  = bus_we && sel.softrst && (bus_wdata == SOFTRST_KEY);

  bcb_display #(.NUM_CHARS(NUM_CHARS), .CIDX_W(CIDX_W)) u_disp (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_word (bus_we && sel.hexword),
    .wr_chr  (bus_we && sel.chr),
    .chr_idx (chr_idx),
    .wdata   (bus_wdata),
    .chars_o (disp_chars_o)
  );

  bcb_i2c u_i2c (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_oe   (bus_we && sel.i2coe),
    .wr_out  (bus_we && sel.i2cout),
    .wr_sel  (bus_we && sel.i2csel),
    .wdata   (bus_wdata),
    .sda_in  (i2c_sda_i),
    .out_q   (i2c_out_q),
    .oe_q    (i2c_oe_q),
    .sel_q   (i2c_sel_q),
    .in_word (i2c_in_word),
    .scl_o   (i2c_scl_o),
    .sda_o   (i2c_sda_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      leds_q    <= 8'h00;
      brk_q     <= BRK_RST;
      gpout_q   <= 8'h00;
      rst_req_q <= 1'b0;
    end else begin
      if (bus_we && sel.leds)  leds_q  <= bus_wdata[7:0];
      if (bus_we && sel.brk)   brk_q   <= bus_wdata[7:0];
      if (bus_we && sel.gpout) gpout_q <= bus_wdata[7:0];
      rst_req_q <= key_wr_evt && !rst_req_q;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (sel.status) rd_mux = strap_big_endian ? STATUS_BE : STATUS_LE;
    if (sel.leds)   rd_mux = {24'b0, leds_q};
    if (sel.brk)    rd_mux = {24'b0, brk_q};
    if (sel.gpout)  rd_mux = {24'b0, gpout_q};
    if (sel.gpin)   rd_mux = i2c_sel_q ? i2c_out_q : 32'h0;
    if (sel.i2cin)  rd_mux = i2c_in_word;
    if (sel.i2coe)  rd_mux = {30'b0, i2c_oe_q};
    if (sel.i2cout) rd_mux = i2c_out_q;
    if (sel.i2csel) rd_mux = {31'b0, i2c_sel_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (bus_re) rdata_q <= rd_mux;
  end

  assign bus_rdata   = rdata_q;
  assign reset_req_o = rst_req_q;
endmodule

// File: rtl/bcb_checks.sv
`timescale 1ns/1ps
module bcb_checks #(
  parameter int ADDR_W = 32,
  parameter int DISP_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [31:0]       bus_wdata,
  input logic              bus_re,
  input logic [31:0]       bus_rdata,
  input logic              rd_hit,
  input logic              disp_wr_evt,
  input logic              reset_req_o,
  input logic              i2c_scl_o,
  input logic              i2c_sda_o,
  input logic [DISP_W-1:0] disp_chars_o
);
  logic b10_wr, k500_wr, byte_rd;
  assign b10_wr  = bus_we && (bus_addr[19:0] == 20'h00B10);
  assign k500_wr = bus_we && (bus_addr[19:0] == 20'h00500) && (bus_wdata == 32'h42);
  assign byte_rd = bus_re && ((bus_addr[19:0] == 20'h00408) ||
                              (bus_addr[19:0] == 20'h00508) ||
                              (bus_addr[19:0] == 20'h00A00));

  // R3: read data holds while no read is made
  a_r3_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_re |=> $stable(bus_rdata));

  // R2: unmapped reads return zero
  a_r2_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && !rd_hit) |=> (bus_rdata == 32'h0));

  // R5: byte registers read back with clear upper bits
  a_r5_byte_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
    byte_rd |=> (bus_rdata[31:8] == 24'h0));

  // R8: reset request lasts one cycle
  a_r8_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req_o |=> !reset_req_o);

  // R8: reset request only follows a key write
  a_r8_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reset_req_o) |-> $past(k500_wr));

  // R10: lines copy the written bits
  a_r10_lines_follow: assert property (@(posedge clk) disable iff (!rst_n)
    b10_wr |=> (i2c_scl_o == $past(bus_wdata[1])) && (i2c_sda_o == $past(bus_wdata[0])));

  // R10: lines steady without a write
  a_r10_lines_steady: assert property (@(posedge clk) disable iff (!rst_n)
    !b10_wr |=> ($stable(i2c_scl_o) && $stable(i2c_sda_o)));

  // R6/R7: display changes only after a display write
  a_r7_disp_steady: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_wr_evt |=> $stable(disp_chars_o));
endmodule

bind board_ctl_bank bcb_checks #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_addr     (bus_addr),
  .bus_we       (bus_we),
  .bus_wdata    (bus_wdata),
  .bus_re       (bus_re),
  .bus_rdata    (bus_rdata),
  .rd_hit       (rd_hit),
  .disp_wr_evt  (disp_wr_evt),
  .reset_req_o  (reset_req_o),
  .i2c_scl_o    (i2c_scl_o),
  .i2c_sda_o    (i2c_sda_o),
  .disp_chars_o (disp_chars_o)
);

// File: tb/board_ctl_bank_tb_top.sv
`timescale 1ns/1ps
module board_ctl_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_re = 1'b0;
  logic [31:0] bus_rdata;
  logic        strap_big_endian = 1'b0;
  logic        i2c_sda_i = 1'b1;
  logic        i2c_scl_o, i2c_sda_o, reset_req_o;
  logic [63:0] disp_chars_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string hexs = "0123456789ABCDEF";

  always #10 clk = ~clk;

  board_ctl_bank dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .strap_big_endian(strap_big_endian), .i2c_sda_i(i2c_sda_i),
    .i2c_scl_o(i2c_scl_o), .i2c_sda_o(i2c_sda_o),
    .reset_req_o(reset_req_o), .disp_chars_o(disp_chars_o)
  );

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [31:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_re = 1'b0;
    d = bus_rdata;
  endtask

  task automatic rd_chk(input string req, input logic [31:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, {32'h0, v}, {32'h0, exp});
  endtask

  function automatic logic [63:0] hex_disp(input logic [31:0] w);
    logic [63:0] r;
    for (int i = 0; i < 8; i++) r[8*i +: 8] = hexs[(w >> (28 - 4*i)) & 15];
    return r;
  endfunction

  task automatic t_reset_state;
    chk("R1 rdata", {32'h0, bus_rdata}, 64'h0);
    chk("R1 lines", {62'h0, i2c_scl_o, i2c_sda_o}, 64'h3);
    chk("R1 reset_req", {63'h0, reset_req_o}, 64'h0);
    chk("R1 display", disp_chars_o, {8{8'h20}});
    rd_chk("R1 leds", 32'h408, 32'h0);
    rd_chk("R1 brk", 32'h508, 32'h0A);
    rd_chk("R1 gpout", 32'hA00, 32'h0);
    rd_chk("R1 oe", 32'hB08, 32'h0);
    rd_chk("R1 i2c out", 32'hB10, 32'h3);
    rd_chk("R1 select", 32'hB18, 32'h1);
  endtask

  task automatic t_decode;
    rd_chk("R2 unmapped read", 32'h004, 32'h0);
    wr(32'hABC0_0408, 32'h5A);
    rd_chk("R2 alias write", 32'h408, 32'h5A);
    rd_chk("R2 alias read", 32'h7770_0408, 32'h5A);
    wr(32'h300, 32'hFF);
    wr(32'h409, 32'h11);
    rd_chk("R2 unmapped write ignored", 32'h408, 32'h5A);
    rd_chk("R2 hexword reads zero", 32'h410, 32'h0);
  endtask

  task automatic t_read_hold;
    rd_chk("R3 read", 32'h408, 32'h5A);
    wr(32'h408, 32'hC3);
    chk("R3 hold without read", {32'h0, bus_rdata}, {32'h0, 32'h5A});
    rd_chk("R3 new value", 32'h408, 32'hC3);
  endtask

  task automatic t_fixed;
    wr(32'h200, 32'hFFFF_FFFF);
    wr(32'h210, 32'hFFFF_FFFF);
    rd_chk("R4 switch", 32'h200, 32'h0);
    rd_chk("R4 jumper", 32'h210, 32'h0);
    strap_big_endian = 1'b0;
    rd_chk("R4 status le", 32'h208, 32'h10);
    strap_big_endian = 1'b1;
    rd_chk("R4 status be", 32'h208, 32'h12);
    wr(32'h208, 32'h0);
    rd_chk("R4 status read-only", 32'h208, 32'h12);
  endtask

  task automatic t_bytes;
    wr(32'h408, 32'h1234_56A5);
    rd_chk("R5 leds", 32'h408, 32'hA5);
    wr(32'h508, 32'hFFFF_FF77);
    rd_chk("R5 brk", 32'h508, 32'h77);
    wr(32'hA00, 32'h8000_0101);
    rd_chk("R5 gpout", 32'hA00, 32'h01);
  endtask

  task automatic t_hexword;
    wr(32'h410, 32'hDEAD_BEEF);
    chk("R6 hex DEADBEEF", disp_chars_o, hex_disp(32'hDEAD_BEEF));
    wr(32'h410, 32'h0123_ABCF);
    chk("R6 hex 0123ABCF", disp_chars_o, hex_disp(32'h0123_ABCF));
    chk("R6 char0 digit", {56'h0, disp_chars_o[7:0]}, 64'h30);
  endtask

  task automatic t_chars;
    logic [63:0] e;
    e = hex_disp(32'h0123_ABCF);
    wr(32'h430, 32'h51);
    e[24 +: 8] = 8'h51;
    chk("R7 char3", disp_chars_o, e);
    wr(32'h450, 32'h1FF);
    e[56 +: 8] = 8'hFF;
    chk("R7 char7 low byte", disp_chars_o, e);
    wr(32'h41C, 32'h99);
    wr(32'h458, 32'h99);
    chk("R7 misaligned and past end ignored", disp_chars_o, e);
  endtask

  task automatic pulse_try(input string req, input logic [31:0] d, input bit expect_pulse);
    @(negedge clk);
    bus_addr = 32'h500; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0;
    chk(req, {63'h0, reset_req_o}, {63'h0, expect_pulse});
    @(posedge clk);
    @(negedge clk);
    chk({req, " next"}, {63'h0, reset_req_o}, 64'h0);
  endtask

  task automatic t_softreset;
    pulse_try("R8 wrong value", 32'h41, 1'b0);
    pulse_try("R8 key", 32'h42, 1'b1);
    pulse_try("R8 key with upper bits", 32'h142, 1'b0);
  endtask

  task automatic t_i2c_regs;
    wr(32'hB08, 32'hFF);
    rd_chk("R9 oe two bits", 32'hB08, 32'h3);
    wr(32'hB10, 32'hA5A5_0002);
    chk("R10 lines", {62'h0, i2c_scl_o, i2c_sda_o}, 64'h2);
    rd_chk("R10 full readback", 32'hB10, 32'hA5A5_0002);
    rd_chk("R11 loopback sel1", 32'hA08, 32'hA5A5_0002);
    wr(32'hB18, 32'hFE);
    rd_chk("R9 select one bit", 32'hB18, 32'h0);
    rd_chk("R11 loopback sel0", 32'hA08, 32'h0);
    wr(32'hB10, 32'h1);
    chk("R10 lines sda only", {62'h0, i2c_scl_o, i2c_sda_o}, 64'h1);
    wr(32'hB08, 32'h0);
    chk("R10 lines steady", {62'h0, i2c_scl_o, i2c_sda_o}, 64'h1);
  endtask

  task automatic t_i2c_input;
    i2c_sda_i = 1'b0;
    rd_chk("R12 sda low", 32'hB00, 32'h2);
    i2c_sda_i = 1'b1;
    rd_chk("R12 sda high", 32'hB00, 32'h3);
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog (R1-R12 run): actual hung expected done");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_decode();
    t_read_hold();
    t_fixed();
    t_bytes();
    t_hexword();
    t_chars();
    t_softreset();
    t_i2c_regs();
    t_i2c_input();
    done = 1;
    finish_run();
  end
endmodule